// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block collects 96 level-sensitive interrupt lines, arranged as three groups of 32, and presents two requests to a processor: a normal request and a fast request. Each line carries a 6-bit priority and a route bit that selects which of the two requests it feeds. Software can also raise any line on its own and can block lines one at a time or as a whole.

For each request, a selector picks the eligible line with the smallest priority value. On a tie, the line with the larger index wins. The winner's number is latched when the request is raised. A request stays raised, with its number frozen, until software re-arms that request through the control word. After the re-arm, the selector runs again.

Software reaches the block through a word-only register bus. The request channel uses valid/ready. Ready is tied high, so there is never back-pressure: a request is accepted in every cycle that valid is high. Read data comes back one cycle after the read is accepted, marked by a one-cycle read-valid pulse. Writes return nothing.

Top module: `lvintc`

## Requirements
- R1: `bus_ready` is always high. An accepted read raises `rd_valid` with its data in the next cycle. An accepted write leaves `rd_valid` low in the next cycle.
- R2: After reset, both requests are low, both winner codes are 0, every group mask is all ones, and all pending state, software bits and per-line settings are 0.
- R3: The revision word at 0x000 reads 0x21 and the status word at 0x014 reads 1. The protection word at 0x04C reads 0. Any other offset reads 0 and ignores writes. This includes the unused fourth group slot (0x0E0-0x0FF), line slots at 96 and above (0x280 up), and misaligned addresses.
- R4: Group g occupies 0x080 + 0x20*g. Its word +0x00 shows the line levels sampled one cycle earlier. A rising line sets its pending bit in the same edge.
- R5: When any line of a group falls, that group's pending word becomes the current levels OR the group's software bits.
- R6: Group word +0x04 writes the whole mask (1 = blocked). A write to +0x08 clears the mask bits where the data has ones. A write to +0x0C sets the mask bits where the data has ones. +0x08 and +0x0C read 0.
- R7: Group word +0x10 ORs the data into the software bits and into pending, and reads back the software bits. Group word +0x14 clears software bits where the data has ones and then loads pending with the remaining software bits AND the current levels.
- R8: Group word +0x18 reads pending AND NOT mask AND NOT route. Group word +0x1C reads pending AND NOT mask AND route.
- R9: Line n has a settings word at 0x100 + 4*n. Bits [7:2] hold the priority, bit 0 holds the route (1 = fast request), and bit 1 reads 0.
- R10: The winner is the eligible line with the smallest priority value, with the larger line index winning ties. Its code is 32*group + bit. The code reads at 0x040 (normal) and 0x044 (fast). Reading a code changes nothing.
- R11: A request rises in the cycle after an eligible source exists while the request is low. The code is latched at that moment and both stay unchanged until a write to control 0x048 with bit 0 (normal) or bit 1 (fast). That write drops the request in the next cycle.
- R12: Control bit 2 is a global mask that prevents either request from rising while it is set. The bit reads back at the same position.
- R13: System word 0x010 keeps bit 0 and reads it back. Writing 1 to its bit 1 returns all state to the reset values of R2 in the next cycle. Word 0x050 keeps its low 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_BANKS*32 | Level interrupt lines, line n on bit n |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request ready, always high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| irq_req | output | 1 | Normal interrupt request |
| irq_code | output | clog2(NUM_BANKS*32) | Latched normal winner |
| fiq_req | output | 1 | Fast interrupt request |
| fiq_code | output | clog2(NUM_BANKS*32) | Latched fast winner |

## Verification
The bench builds the block with its default parameters: three groups of 32 lines, 6-bit priorities and a 12-bit address. With these values, it can place competing sources in different groups, including a cross-group priority tie between lines 35 and 64. It can also reach the empty fourth group slot and the first line slot past the end (96), and check that both are ignored. The full 6-bit priority field can be written and read back, and the software-set and software-clear interplay with a falling line can be exercised inside a single group.

// File: rtl/lvintc_pkg.sv
package lvintc_pkg;

  // Global word offsets (low 7 address bits)
  localparam logic [6:0] OFF_REV      = 7'h00;
  localparam logic [6:0] OFF_SYSCFG   = 7'h10;
  localparam logic [6:0] OFF_STATUS   = 7'h14;
  localparam logic [6:0] OFF_CODE_IRQ = 7'h40;
  localparam logic [6:0] OFF_CODE_FIQ = 7'h44;
  localparam logic [6:0] OFF_CTRL     = 7'h48;
  localparam logic [6:0] OFF_PROT     = 7'h4C;
  localparam logic [6:0] OFF_IDLE     = 7'h50;

  // First word index of the per-line settings area (0x100 / 4)
  localparam int LINE_WORD_BASE = 64;

  // Word select inside one group slot
  typedef enum logic [2:0] {
    BR_RAW  = 3'd0,
    BR_MASK = 3'd1,
    BR_MCLR = 3'd2,
    BR_MSET = 3'd3,
    BR_SSET = 3'd4,
    BR_SCLR = 3'd5,
    BR_PIRQ = 3'd6,
    BR_PFIQ = 3'd7
  } bank_reg_e;

endpackage

// File: rtl/lvintc_bank.sv
module lvintc_bank
  import lvintc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] lines_i,
  input  logic         wr_en,
  input  bank_reg_e    wreg,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] swi_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] raw_q, mask_q, swi_q, pend_q;
  logic [W-1:0] mask_n, swi_n, pend_n;
  logic [W-1:0] rise, fall;

  assign rise = lines_i & ~raw_q;
  assign fall = raw_q & ~lines_i;

  always_comb begin
    mask_n = mask_q;
    swi_n  = swi_q;
    // Line events first: any drop rebuilds the group, a rise only adds.
    if (|fall) pend_n = lines_i | swi_q;
    else       pend_n = pend_q | rise;
    // Bus writes are applied on top of the line update.
    if (wr_en) begin
      unique case (wreg)
        BR_MASK: mask_n = wdata;
        BR_MCLR: mask_n = mask_q & ~wdata;
        BR_MSET: mask_n = mask_q | wdata;
        BR_SSET: begin
          swi_n  = swi_q | wdata;
          pend_n = pend_n | wdata;
        end
        BR_SCLR: begin
          swi_n  = swi_q & ~wdata;
          pend_n = swi_n & lines_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '1;
      swi_q  <= '0;
      pend_q <= '0;
    end else if (soft_rst) begin
      raw_q  <= '0;
      mask_q <= '1;
      swi_q  <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= lines_i;
      mask_q <= mask_n;
      swi_q  <= swi_n;
      pend_q <= pend_n;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign swi_o  = swi_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/lvintc_linecfg.sv
module lvintc_linecfg #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [PRIO_W-1:0]   wprio,
  input  logic                wroute,
  output logic [PRIO_W-1:0]   rd_prio,
  output logic                rd_route,
  output logic [N*PRIO_W-1:0] prio_flat,
  output logic [N-1:0]        route_flat
);

  logic [PRIO_W-1:0] prio_q [N];
  logic [N-1:0]      route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
      route_q <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      prio_q[idx]  <= wprio;
      route_q[idx] <= wroute;
    end
  end

  assign rd_prio  = prio_q[idx];
  assign rd_route = route_q[idx];

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end
  assign route_flat = route_q;

endmodule

// File: rtl/lvintc_arb.sv
module lvintc_arb #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);

  logic [PRIO_W-1:0] best;

  // Ascending scan; "<=" hands ties to the later (higher) index.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found_o || prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
        found_o = 1'b1;
        best    = prio_flat[i*PRIO_W +: PRIO_W];
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lvintc_agree.sv
module lvintc_agree #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rearm,
  input  logic             gmask,
  input  logic             has_src,
  input  logic [IDX_W-1:0] win,
  output logic             req_o,
  output logic [IDX_W-1:0] code_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      code_o <= '0;
    end else if (soft_rst) begin
      req_o  <= 1'b0;
      code_o <= '0;
    end else if (rearm) begin
      req_o <= 1'b0;
    end else if (!req_o && has_src && !gmask) begin
      req_o  <= 1'b1;
      code_o <= win;
    end
  end

endmodule

// File: rtl/lvintc.sv
module lvintc
  import lvintc_pkg::*;
#(
  parameter int          NUM_BANKS = 3,
  parameter int          PRIO_W    = 6,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [7:0]  REVISION  = 8'h21
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_BANKS*DATA_W-1:0]            irq_lines,
  input  logic                                   bus_valid,
  output logic                                   bus_ready,
  input  logic                                   bus_write,
  input  logic [ADDR_W-1:0]                      bus_addr,
  input  logic [DATA_W-1:0]                      bus_wdata,
  output logic                                   rd_valid,
  output logic [DATA_W-1:0]                      rd_data,
  output logic                                   irq_req,
  output logic [$clog2(NUM_BANKS*DATA_W)-1:0]    irq_code,
  output logic                                   fiq_req,
  output logic [$clog2(NUM_BANKS*DATA_W)-1:0]    fiq_code
);

  localparam int NUM_LINES = NUM_BANKS * DATA_W;
  localparam int CODE_W    = $clog2(NUM_LINES);
  localparam int WORD_W    = ADDR_W - 2;

  // ---------------- bus decode ----------------
  logic acc_wr, acc_rd, addr_ok;
  logic in_glob, in_bank, in_line, bank_ok, line_ok;
  logic [1:0]        bsel;
  bank_reg_e         breg;
  logic [6:0]        goff;
  logic [WORD_W-1:0] line_off;

  assign bus_ready = 1'b1;
  assign acc_wr    = bus_valid & bus_write;
  assign acc_rd    = bus_valid & ~bus_write;
  assign addr_ok   = (bus_addr[1:0] == 2'b00);
  assign goff      = bus_addr[6:0];
  assign in_glob   = (bus_addr[ADDR_W-1:7] == '0);
  assign in_bank   = (bus_addr[ADDR_W-1:7] == (ADDR_W-7)'(1));
  assign in_line   = |bus_addr[ADDR_W-1:8];
  assign bsel      = bus_addr[6:5];
  assign breg      = bank_reg_e'(bus_addr[4:2]);
  assign bank_ok   = (32'(bsel) < NUM_BANKS);
  assign line_off  = bus_addr[ADDR_W-1:2] - WORD_W'(LINE_WORD_BASE);
  assign line_ok   = (32'(line_off) < NUM_LINES);

  logic glob_wr;
  logic soft_rst;
  logic rearm_irq, rearm_fiq;
  assign glob_wr   = acc_wr & addr_ok & in_glob;
  assign soft_rst  = glob_wr & (goff == OFF_SYSCFG) & bus_wdata[1];
  assign rearm_irq = glob_wr & (goff == OFF_CTRL) & bus_wdata[0];
  assign rearm_fiq = glob_wr & (goff == OFF_CTRL) & bus_wdata[1];

  // ---------------- global settings ----------------
  logic       gmask_q, autoidle_q;
  logic [1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q    <= 1'b0;
      autoidle_q <= 1'b0;
      idle_q     <= '0;
    end else if (soft_rst) begin
      gmask_q    <= 1'b0;
      autoidle_q <= 1'b0;
      idle_q     <= '0;
    end else if (glob_wr) begin
      if (goff == OFF_SYSCFG) autoidle_q <= bus_wdata[0];
      if (goff == OFF_CTRL)   gmask_q    <= bus_wdata[2];
      if (goff == OFF_IDLE)   idle_q     <= bus_wdata[1:0];
    end
  end

  // ---------------- groups ----------------
  logic [DATA_W-1:0]    raw_b  [NUM_BANKS];
  logic [DATA_W-1:0]    mask_b [NUM_BANKS];
  logic [DATA_W-1:0]    swi_b  [NUM_BANKS];
  logic [DATA_W-1:0]    pend_b [NUM_BANKS];
  logic [NUM_LINES-1:0] pend_all, mask_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic we;
    assign we = acc_wr & addr_ok & in_bank & (bsel == 2'(b));
    lvintc_bank #(.W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .lines_i (irq_lines[b*DATA_W +: DATA_W]),
      .wr_en   (we),
      .wreg    (breg),
      .wdata   (bus_wdata),
      .raw_o   (raw_b[b]),
      .mask_o  (mask_b[b]),
      .swi_o   (swi_b[b]),
      .pend_o  (pend_b[b])
    );
    assign pend_all[b*DATA_W +: DATA_W] = pend_b[b];
    assign mask_all[b*DATA_W +: DATA_W] = mask_b[b];
  end

  // ---------------- per-line settings ----------------
  logic [PRIO_W-1:0]           rd_prio;
  logic                        rd_route;
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  logic [NUM_LINES-1:0]        route_flat;
  logic                        line_we;

  assign line_we = acc_wr & addr_ok & in_line & line_ok;

  lvintc_linecfg #(.N(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(CODE_W)) u_linecfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_en     (line_we),
    .idx       (line_off[CODE_W-1:0]),
    .wprio     (bus_wdata[2 +: PRIO_W]),
    .wroute    (bus_wdata[0]),
    .rd_prio   (rd_prio),
    .rd_route  (rd_route),
    .prio_flat (prio_flat),
    .route_flat(route_flat)
  );

  // ---------------- selection and request stages ----------------
  logic [NUM_LINES-1:0] elig_irq, elig_fiq;
  logic                 has_irq, has_fiq;
  logic [CODE_W-1:0]    win_irq, win_fiq;

  assign elig_irq = pend_all & ~mask_all & ~route_flat;
  assign elig_fiq = pend_all & ~mask_all &  route_flat;

  lvintc_arb #(.N(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(CODE_W)) u_arb_irq (
    .elig(elig_irq), .prio_flat(prio_flat), .found_o(has_irq), .idx_o(win_irq)
  );
  lvintc_arb #(.N(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(CODE_W)) u_arb_fiq (
    .elig(elig_fiq), .prio_flat(prio_flat), .found_o(has_fiq), .idx_o(win_fiq)
  );

  lvintc_agree #(.IDX_W(CODE_W)) u_agree_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rearm(rearm_irq),
    .gmask(gmask_q), .has_src(has_irq), .win(win_irq),
    .req_o(irq_req), .code_o(irq_code)
  );
  lvintc_agree #(.IDX_W(CODE_W)) u_agree_fiq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rearm(rearm_fiq),
    .gmask(gmask_q), .has_src(has_fiq), .win(win_fiq),
    .req_o(fiq_req), .code_o(fiq_code)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rdata_n;
  logic [DATA_W-1:0] route_sel;

  always_comb begin
    route_sel = '0;
    if (bank_ok) route_sel = route_flat[32'(bsel)*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata_n = '0;
    if (addr_ok) begin
      if (in_glob) begin
        unique case (goff)
          OFF_REV:      rdata_n = DATA_W'(REVISION);
          OFF_SYSCFG:   rdata_n = DATA_W'(autoidle_q);
          OFF_STATUS:   rdata_n = DATA_W'(1);
          OFF_CODE_IRQ: rdata_n = DATA_W'(irq_code);
          OFF_CODE_FIQ: rdata_n = DATA_W'(fiq_code);
          OFF_CTRL:     rdata_n = DATA_W'({gmask_q, 2'b00});
          OFF_IDLE:     rdata_n = DATA_W'(idle_q);
          default:      rdata_n = '0;
        endcase
      end else if (in_bank && bank_ok) begin
        unique case (breg)
          BR_RAW:  rdata_n = raw_b[bsel];
          BR_MASK: rdata_n = mask_b[bsel];
          BR_SSET: rdata_n = swi_b[bsel];
          BR_PIRQ: rdata_n = pend_b[bsel] & ~mask_b[bsel] & ~route_sel;
          BR_PFIQ: rdata_n = pend_b[bsel] & ~mask_b[bsel] &  route_sel;
          default: rdata_n = '0;
        endcase
      end else if (in_line && line_ok) begin
        rdata_n = DATA_W'({rd_prio, 1'b0, rd_route});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= rdata_n;
    end
  end

endmodule

// File: rtl/lvintc_chk.sv
module lvintc_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_req,
  input logic              fiq_req,
  input logic [CODE_W-1:0] irq_code,
  input logic [CODE_W-1:0] fiq_code,
  input logic              gmask
);

  assert_read_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  assert_write_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !rd_valid);

  assert_status_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(12'h014)) |=> (rd_data == DATA_W'(1)));

  assert_irq_code_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && $past(irq_req)) |-> $stable(irq_code));

  assert_fiq_code_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && $past(fiq_req)) |-> $stable(fiq_code));

  assert_rearm_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(12'h048) && bus_wdata[0]) |=> !irq_req);

  assert_irq_gmask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !$past(gmask));

  assert_fiq_gmask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_req) |-> !$past(gmask));

  assert_soft_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(12'h010) && bus_wdata[1])
      |=> (!irq_req && !fiq_req));

endmodule

bind lvintc lvintc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .irq_req  (irq_req),
  .fiq_req  (fiq_req),
  .irq_code (irq_code),
  .fiq_code (fiq_code),
  .gmask    (gmask_q)
);

// File: tb/test_lvintc.sv
module test_lvintc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_lines = '0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_req, fiq_req;
  logic [6:0]  irq_code, fiq_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic last_rv;

  always #4 clk = ~clk;

  lvintc i_lvintc (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_req(irq_req), .irq_code(irq_code),
    .fiq_req(fiq_req), .fiq_code(fiq_code)
  );

  // {write, address, data-or-expected, requirement number}
  localparam int NV = 25;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 12'h084, 32'hFFFF_FFFF, 8'd2},   // R2 group 0 mask
    {1'b0, 12'h0C4, 32'hFFFF_FFFF, 8'd2},   // R2 group 2 mask
    {1'b0, 12'h040, 32'h0000_0000, 8'd2},   // R2 normal code
    {1'b0, 12'h000, 32'h0000_0021, 8'd3},   // R3 revision
    {1'b0, 12'h014, 32'h0000_0001, 8'd3},   // R3 status
    {1'b0, 12'h04C, 32'h0000_0000, 8'd3},   // R3 protection
    {1'b1, 12'h0E4, 32'h0000_DEAD, 8'd3},   // R3 fourth slot write
    {1'b0, 12'h0E4, 32'h0000_0000, 8'd3},   // R3 fourth slot reads 0
    {1'b1, 12'h088, 32'h0000_00F0, 8'd6},   // R6 mask clear
    {1'b0, 12'h084, 32'hFFFF_FF0F, 8'd6},
    {1'b1, 12'h08C, 32'h0000_0030, 8'd6},   // R6 mask set
    {1'b0, 12'h084, 32'hFFFF_FF3F, 8'd6},
    {1'b1, 12'h0A4, 32'h1234_5678, 8'd6},   // R6 full mask write
    {1'b0, 12'h0A4, 32'h1234_5678, 8'd6},
    {1'b1, 12'h104, 32'h0000_00FF, 8'd9},   // R9 line 1 settings
    {1'b0, 12'h104, 32'h0000_00FD, 8'd9},
    {1'b1, 12'h050, 32'h0000_000F, 8'd13},  // R13 idle word
    {1'b0, 12'h050, 32'h0000_0003, 8'd13},
    {1'b1, 12'h010, 32'h0000_0001, 8'd13},  // R13 autoidle
    {1'b0, 12'h010, 32'h0000_0001, 8'd13},
    {1'b1, 12'h280, 32'h0000_007F, 8'd3},   // R3 line 96 does not exist
    {1'b0, 12'h280, 32'h0000_0000, 8'd3},
    {1'b1, 12'h0A4, 32'hFFFF_FFFF, 8'd6},
    {1'b1, 12'h084, 32'hFFFF_FFFF, 8'd6},
    {1'b1, 12'h104, 32'h0000_0000, 8'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    last_rv = rd_valid;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
    last_rv = rd_valid;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R2: requests low out of reset
    check("R2 irq_req", 32'(irq_req), 32'd0);
    check("R2 fiq_req", 32'(fiq_req), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      if (VEC[i][52]) bus_wr(VEC[i][51:40], VEC[i][39:8]);
      else begin
        bus_rd(VEC[i][51:40], v);
        check($sformatf("R%0d table %0d", VEC[i][7:0], i), v, VEC[i][39:8]);
      end
    end

    // R1: read returns valid data, write does not
    rd_check("R1 read", 12'h014, 32'd1);
    check("R1 rd_valid after read", 32'(last_rv), 32'd1);
    bus_wr(12'h050, 32'd0);
    check("R1 rd_valid after write", 32'(last_rv), 32'd0);

    // R4: level capture and masked source stays quiet
    @(negedge clk); irq_lines[5] = 1'b1;
    tick(2);
    rd_check("R4 raw word", 12'h080, 32'h20);
    check("R6 masked line gives no request", 32'(irq_req), 32'd0);
    bus_wr(12'h088, 32'h20);
    tick(1);
    check("R11 request rises", 32'(irq_req), 32'd1);
    rd_check("R8 pending normal view", 12'h098, 32'h20);
    rd_check("R10 code of line 5", 12'h040, 32'd5);

    // R10: cross-group tie, larger index wins
    @(negedge clk); irq_lines[35] = 1'b1; irq_lines[64] = 1'b1;
    bus_wr(12'h114, 32'h28);   // line 5 priority 10
    bus_wr(12'h18C, 32'h08);   // line 35 priority 2
    bus_wr(12'h200, 32'h08);   // line 64 priority 2
    bus_wr(12'h0A8, 32'h08);
    bus_wr(12'h0C8, 32'h01);
    check("R11 code frozen while raised", 32'(irq_code), 32'd5);
    bus_wr(12'h048, 32'h1);
    check("R11 re-arm drops request", 32'(irq_req), 32'd0);
    tick(1);
    check("R11 request again", 32'(irq_req), 32'd1);
    check("R10 tie goes to line 64", 32'(irq_code), 32'd64);

    // R10: lower value wins after priority change and re-arm
    bus_wr(12'h200, 32'hA0);   // line 64 priority 40
    check("R11 code unchanged by settings", 32'(irq_code), 32'd64);
    bus_wr(12'h048, 32'h1);
    tick(1);
    check("R10 smallest value line 35", 32'(irq_code), 32'd35);

    // R8 / R9: route line 35 to the fast request
    bus_wr(12'h18C, 32'h09);
    tick(1);
    check("R9 route raises fast request", 32'(fiq_req), 32'd1);
    rd_check("R10 fast code", 12'h044, 32'd35);
    rd_check("R8 pending fast view", 12'h0BC, 32'h08);
    rd_check("R8 pending normal view excludes routed", 12'h0B8, 32'h0);
    check("R10 code read does not acknowledge", 32'(fiq_req), 32'd1);

    // R12: global mask
    bus_wr(12'h048, 32'h5);
    tick(3);
    check("R12 masked no request", 32'(irq_req), 32'd0);
    rd_check("R12 control readback", 12'h048, 32'h4);
    bus_wr(12'h048, 32'h0);
    tick(1);
    check("R12 request after unmask", 32'(irq_req), 32'd1);
    check("R12 winner after unmask", 32'(irq_code), 32'd5);

    // R7 / R5: software bits and falling line
    bus_wr(12'h090, 32'h200);
    rd_check("R7 software readback", 12'h090, 32'h200);
    bus_wr(12'h088, 32'h200);
    rd_check("R7 software adds pending", 12'h098, 32'h220);
    @(negedge clk); irq_lines[5] = 1'b0;
    tick(1);
    rd_check("R5 drop rebuilds pending", 12'h098, 32'h200);
    bus_wr(12'h094, 32'h200);
    rd_check("R7 software cleared", 12'h090, 32'h0);
    rd_check("R7 clear reloads pending", 12'h098, 32'h0);
    @(negedge clk); irq_lines[5] = 1'b1;
    tick(1);
    bus_wr(12'h090, 32'h220);
    bus_wr(12'h094, 32'h200);
    rd_check("R7 pending is software AND level", 12'h098, 32'h20);
    rd_check("R7 remaining software bit", 12'h090, 32'h20);

    // R13: soft reset
    bus_wr(12'h050, 32'h2);
    bus_wr(12'h010, 32'h3);
    check("R13 normal request cleared", 32'(irq_req), 32'd0);
    check("R13 fast request cleared", 32'(fiq_req), 32'd0);
    rd_check("R13 mask restored", 12'h084, 32'hFFFF_FFFF);
    rd_check("R13 line settings cleared", 12'h200, 32'h0);
    rd_check("R13 fast code cleared", 12'h044, 32'h0);
    rd_check("R13 autoidle cleared", 12'h010, 32'h0);
    rd_check("R13 idle cleared", 12'h050, 32'h0);
    rd_check("R13 software cleared", 12'h090, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule